// File: doc/BRIEF.md
# Multi-Input Tamper Detection Unit

This unit watches five external tamper pins. Each pin has its own two-bit action mode, its own edge polarity and its own debounce option. An event on a pin sets a sticky per-pin flag. Depending on the mode, the event also raises a wake request or copies a free-running counter value into a timestamp register. The counter comes from outside the block.

A fourth mode runs a driven-pattern loop. A 7-bit LFSR drives one output pin, and the wiring routes that pin back to every input set to this mode. At every tick of the slow sample strobe, each of those inputs is compared with the pattern currently on the output. The pattern then moves on, so a returned value has a full strobe period to come back. A mismatch is a tamper event.

The control word is loaded only while the block is disabled. This lets firmware configure all pins first and then arm the block. None of the interfaces carry a data stream: every port is a plain level or pulse with no handshake.

Top module: `tamper_unit`

## Requirements
- R1: After reset the control word reads 0x00000000, so all pins are off. Only the implemented bits hold a written 1: bits 9:0 (action), 20:16 (edge) and 28:24 (debounce). The control word therefore reads back masked with 0x1F1F03FF.
- R2: A control write is taken only when `en` is low. A write made while `en` is high leaves `ctrl_q` unchanged.
- R3: Pin n is configured by action field bits [2n+1:2n]. The codes are: 0 off, 1 wake, 2 timestamp capture, 3 pattern loop. A pin in mode 0 never sets a flag.
- R4: Control bit 16+n selects the event edge for pin n: 1 means rising, 0 means falling. The opposite edge sets nothing.
- R5: When control bit 24+n is 1, pin n takes a new level only after it is seen differing on 4 consecutive `sample_stb` ticks. A shorter pulse produces no event. When the bit is 0, the synchronized pin is used directly, and the flag shows 3 clocks after the pin changes.
- R6: A mode-1 event sets `flag[n]`. `wake` is high while any flagged pin is in mode 1.
- R7: A mode-2 event sets `flag[n]` and does not raise `wake`.
- R8: `ts_q` loads `ts_cnt` on a capture event (mode 2, or a mode-3 mismatch) only when every flag was clear. Otherwise `ts_q` holds its value.
- R9: Flags are sticky. Writing 1 to bit n of `flag_clr` clears only `flag[n]`. An event in the same cycle as the clear wins.
- R10: No flag is set while `en` is low.
- R11: In mode 3, `loop_out` changes only on `sample_stb`. At each strobe, the synchronized pin is compared with the current `loop_out`. An intact loopback never flags. A broken loop sets the flag and captures the timestamp.
- R12: In mode 3, the edge and debounce bits of that pin have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; also locks the control word |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Current control word |
| sample_stb | input | 1 | Slow sample strobe for debounce and pattern loop |
| tamp_in | input | 5 | Tamper pins (asynchronous) |
| loop_out | output | 1 | Driven pattern for loop mode |
| ts_cnt | input | 32 | Free-running counter value |
| flag_clr | input | 5 | Per-pin flag clear, write 1 to clear |
| flag | output | 5 | Sticky per-pin tamper flags |
| wake | output | 1 | Wake request |
| ts_q | output | 32 | Captured timestamp |

## Verification
The hardest cases to reach from the ports are a debounced pulse that lasts exactly one strobe fewer than the acceptance count, and a loop that fails only after running clean. The bench steps the strobe by hand, so it can hold a pin for three ticks and then four. It also wires `loop_out` back to the mode-3 pins, runs twenty clean strobes, and then ties one return path low. This forces a mismatch within a few pattern steps, with the edge and debounce bits set to confirm they are bypassed. A vector table covers every action code, both edge polarities and several pin positions.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [1:0] {
    ACT_OFF   = 2'd0,
    ACT_WAKE  = 2'd1,
    ACT_STAMP = 2'd2,
    ACT_LOOP  = 2'd3
  } act_e;

  localparam int CTRL_W   = 32;
  localparam int ACT_LSB  = 0;
  localparam int EDGE_LSB = 16;
  localparam int DEB_LSB  = 24;

  // implemented bits of the control word for n pins
  function automatic logic [CTRL_W-1:0] ctrl_mask(input int n);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[ACT_LSB + 2*i]     = 1'b1;
      m[ACT_LSB + 2*i + 1] = 1'b1;
      m[EDGE_LSB + i]      = 1'b1;
      m[DEB_LSB + i]       = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tamper_chan.sv
module tamper_chan
  import tamper_pkg::*;
#(
  parameter int DEB_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       stb,
  input  logic       pin,
  input  logic [1:0] mode,
  input  logic       edge_rise,
  input  logic       deb_en,
  input  logic       loop_ref,
  output logic       evt_wake,
  output logic       evt_stamp
);
  localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_TICKS - 1);

  logic [1:0]    sync_q;
  logic          s_lvl;
  logic          deb_lvl;
  logic [CW-1:0] deb_cnt;
  logic          lvl;
  logic          prev_q;
  logic          hit;
  act_e          act;

  assign act   = act_e'(mode);
  assign s_lvl = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_lvl <= 1'b0;
      deb_cnt <= '0;
    end else if (stb) begin
      if (s_lvl != deb_lvl) begin
        if (deb_cnt == CNT_LAST) begin
          deb_lvl <= s_lvl;
          deb_cnt <= '0;
        end else begin
          deb_cnt <= deb_cnt + 1'b1;
        end
      end else begin
        deb_cnt <= '0;
      end
    end
  end

  assign lvl = deb_en ? deb_lvl : s_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    if (edge_rise) hit = lvl & ~prev_q;
    else           hit = ~lvl & prev_q;
  end

  always_comb begin
    evt_wake  = en && (act == ACT_WAKE) && hit;
    evt_stamp = en && (((act == ACT_STAMP) && hit) ||
                       ((act == ACT_LOOP) && stb && (s_lvl != loop_ref)));
  end
endmodule

// File: rtl/tamper_lfsr.sv
module tamper_lfsr #(
  parameter int           W    = 7,
  parameter logic [W-1:0] TAPS = 7'b1100000,
  parameter logic [W-1:0] SEED = 7'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic out_bit
);
  logic [W-1:0] q;
  logic         fb;

  assign fb      = ^(q & TAPS);
  assign out_bit = q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= SEED;
    else if (adv) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/tamper_record.sv
module tamper_record #(
  parameter int N    = 5,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    evt_wake,
  input  logic [N-1:0]    evt_stamp,
  input  logic [N-1:0]    wake_sel,
  input  logic [N-1:0]    clr,
  input  logic [TS_W-1:0] ts_cnt,
  output logic [N-1:0]    flag,
  output logic            wake,
  output logic [TS_W-1:0] ts_q
);
  logic [N-1:0] evt_any;
  logic         ts_load;

  assign evt_any = evt_wake | evt_stamp;
  assign ts_load = (|evt_stamp) && (flag == '0);
  assign wake    = |(flag & wake_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | evt_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ts_q <= '0;
    else if (ts_load) ts_q <= ts_cnt;
  end
endmodule

// File: rtl/tamper_unit.sv
module tamper_unit
  import tamper_pkg::*;
#(
  parameter int N_PINS    = 5,
  parameter int TS_W      = 32,
  parameter int DEB_TICKS = 4,
  parameter int LFSR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              sample_stb,
  input  logic [N_PINS-1:0] tamp_in,
  output logic              loop_out,
  input  logic [TS_W-1:0]   ts_cnt,
  input  logic [N_PINS-1:0] flag_clr,
  output logic [N_PINS-1:0] flag,
  output logic              wake,
  output logic [TS_W-1:0]   ts_q
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(N_PINS);

  logic [N_PINS-1:0] evt_wake;
  logic [N_PINS-1:0] evt_stamp;
  logic [N_PINS-1:0] wake_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl_q <= '0;
    else if (ctrl_we && !en) ctrl_q <= ctrl_wdata & MASK;
  end

  tamper_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (en && sample_stb),
    .out_bit (loop_out)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_chan
    logic [1:0] mode_i;
    assign mode_i      = ctrl_q[ACT_LSB + 2*i +: 2];
    assign wake_sel[i] = (act_e'(mode_i) == ACT_WAKE);

    tamper_chan #(.DEB_TICKS(DEB_TICKS)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .stb       (sample_stb),
      .pin       (tamp_in[i]),
      .mode      (mode_i),
      .edge_rise (ctrl_q[EDGE_LSB + i]),
      .deb_en    (ctrl_q[DEB_LSB + i]),
      .loop_ref  (loop_out),
      .evt_wake  (evt_wake[i]),
      .evt_stamp (evt_stamp[i])
    );
  end

  tamper_record #(.N(N_PINS), .TS_W(TS_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_wake  (evt_wake),
    .evt_stamp (evt_stamp),
    .wake_sel  (wake_sel),
    .clr       (flag_clr),
    .ts_cnt    (ts_cnt),
    .flag      (flag),
    .wake      (wake),
    .ts_q      (ts_q)
  );
endmodule

// File: rtl/tamper_unit_chk.sv
module tamper_unit_chk #(
  parameter int N_PINS = 5,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ctrl_we,
  input logic [31:0]       ctrl_q,
  input logic              sample_stb,
  input logic              loop_out,
  input logic [TS_W-1:0]   ts_cnt,
  input logic [N_PINS-1:0] flag_clr,
  input logic [N_PINS-1:0] flag,
  input logic              wake,
  input logic [TS_W-1:0]   ts_q
);
  // R2
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ctrl_we) |=> $stable(ctrl_q));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == '0) |=> ((flag & $past(flag)) == $past(flag)));

  // R10
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((flag & ~$past(flag)) == '0));

  // R11
  loop_step_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(loop_out));

  // R8
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != '0) |=> $stable(ts_q));

  // R8
  ts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ts_q) |-> (ts_q == $past(ts_cnt)));

  // R6
  wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (flag != '0));
endmodule

bind tamper_unit tamper_unit_chk #(.N_PINS(N_PINS), .TS_W(TS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ctrl_we    (ctrl_we),
  .ctrl_q     (ctrl_q),
  .sample_stb (sample_stb),
  .loop_out   (loop_out),
  .ts_cnt     (ts_cnt),
  .flag_clr   (flag_clr),
  .flag       (flag),
  .wake       (wake),
  .ts_q       (ts_q)
);

// File: tb/tamper_unit_test.sv
module tamper_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_q;
  logic        sample_stb = 1'b0;
  logic [4:0]  tin = '0;
  logic [4:0]  tamp_in;
  logic        loop_out;
  logic [31:0] ts_cnt = '0;
  logic [4:0]  flag_clr = '0;
  logic [4:0]  flag;
  logic        wake;
  logic [31:0] ts_q;
  logic        loop_mode = 1'b0;
  logic        brk = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign tamp_in = loop_mode ? {(brk ? 1'b0 : loop_out), {4{loop_out}}} : tin;

  tamper_unit uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .sample_stb(sample_stb),
    .tamp_in(tamp_in), .loop_out(loop_out), .ts_cnt(ts_cnt),
    .flag_clr(flag_clr), .flag(flag), .wake(wake), .ts_q(ts_q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d; tick(1);
    ctrl_we = 1'b0; tick(1);
  endtask

  task automatic strobe();
    sample_stb = 1'b1; tick(1);
    sample_stb = 1'b0; tick(3);
  endtask

  task automatic clear_all();
    flag_clr = 5'h1F; tick(1); flag_clr = '0; tick(1);
  endtask

  // {chan[10:8], mode[7:6], rise[5], v0[4], v1[3], flag[2], wake[1], ts[0]}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd4, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd4, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ts_before;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 ctrl reset", ctrl_q, 32'h0);
    chk("R9 flags reset", {27'd0, flag}, 32'h0);
    chk("R8 ts reset", ts_q, 32'h0);

    // R1 mask
    wr(32'hFFFF_FFFF);
    chk("R1 mask", ctrl_q, 32'h1F1F_03FF);
    // R2 locked while enabled
    en = 1'b1; tick(1);
    wr(32'h0000_0000);
    chk("R2 write ignored", ctrl_q, 32'h1F1F_03FF);
    en = 1'b0; tick(1);
    wr(32'h0);

    // vector table: R3 R4 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      int ch;
      v  = VEC[i];
      ch = int'(v[10:8]);
      en = 1'b0; tin = '0; tick(4);
      clear_all();
      wr((32'(v[7:6]) << (2*ch)) | (32'(v[5]) << (16+ch)));
      tin[ch] = v[4]; tick(4);
      ts_before = ts_q;
      ts_cnt = 32'd1000 + 32'(i);
      en = 1'b1; tick(1);
      tin[ch] = v[3]; tick(4);
      chk("R3/R4 vector flag", {27'd0, flag}, v[2] ? (32'd1 << ch) : 32'd0);
      chk("R6/R7 vector wake", {31'd0, wake}, {31'd0, v[1]});
      chk("R8 vector ts", ts_q, v[0] ? ts_cnt : ts_before);
      en = 1'b0; tin = '0; tick(4);
    end
    clear_all();

    // R10 disabled: no flags
    wr(32'h0001_0001);
    tin[0] = 1'b1; tick(5);
    chk("R10 disabled no flag", {27'd0, flag}, 32'h0);
    chk("R10 disabled no wake", {31'd0, wake}, 32'h0);
    tin = '0; tick(4);

    // R8 first capture only, R9 selective clear
    wr(32'h000A_0088);
    en = 1'b1; ts_cnt = 32'h111; tick(1);
    tin[1] = 1'b1; tick(4);
    chk("R7 capture flag", {27'd0, flag}, 32'h02);
    chk("R8 first ts", ts_q, 32'h111);
    ts_cnt = 32'h222;
    tin[3] = 1'b1; tick(4);
    chk("R8 second capture held", ts_q, 32'h111);
    chk("R9 both flags", {27'd0, flag}, 32'h0A);
    flag_clr = 5'h02; tick(1); flag_clr = '0; tick(1);
    chk("R9 selective clear", {27'd0, flag}, 32'h08);
    tin = '0; tick(4);
    chk("R9 sticky after release", {27'd0, flag}, 32'h08);
    clear_all();
    ts_cnt = 32'h333;
    tin[3] = 1'b1; tick(4);
    chk("R8 reload after clear", ts_q, 32'h333);
    en = 1'b0; tin = '0; tick(4);
    clear_all();

    // R5 debounce: 3 strobes rejected, 4 accepted
    wr(32'h0101_0001);
    en = 1'b1; tick(1);
    tin[0] = 1'b1; tick(3);
    repeat (3) strobe();
    tin[0] = 1'b0; tick(3);
    repeat (3) strobe();
    chk("R5 short pulse rejected", {27'd0, flag}, 32'h0);
    tin[0] = 1'b1; tick(3);
    repeat (3) strobe();
    chk("R5 not yet accepted", {27'd0, flag}, 32'h0);
    strobe();
    chk("R5 accepted on 4th", {27'd0, flag}, 32'h01);
    chk("R6 wake after debounce", {31'd0, wake}, 32'h1);
    en = 1'b0; tin = '0; tick(4);
    clear_all();

    // R11 R12 pattern loop with edge and debounce bits set
    wr(32'h1F1F_03FF);
    loop_mode = 1'b1; tick(4);
    en = 1'b1; ts_cnt = 32'h5A5; tick(1);
    repeat (20) strobe();
    chk("R11 intact loop no flag", {27'd0, flag}, 32'h0);
    brk = 1'b1; tick(4);
    for (int k = 0; k < 16; k++) if (flag == '0) strobe();
    chk("R11 broken loop flag", {27'd0, flag}, 32'h10);
    chk("R12 loop ts capture", ts_q, 32'h5A5);
    chk("R12 loop no wake", {31'd0, wake}, 32'h0);
    en = 1'b0; brk = 1'b0; loop_mode = 1'b0; tick(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule